// File: doc/BRIEF.md
# Multicore interrupt distribution unit

This block sits between a set of shared, level-triggered interrupt sources and a small cluster of cores. Each shared source owns a small configuration record: a destination mask with one bit per core, a delivery mode (fixed core or round-robin over the mask) and a mask bit. Software fills these records through a one-cycle command port, then issues a global enable command. Until that command arrives, nothing reaches any core.

Once a source is enabled, unmasked and high, the block picks one core and raises that core's interrupt line for the source. The line stays high until the chosen core returns a completion pulse for that source. Shared source k always lands on line FIRST_LINE + k of every core's line vector, so the interrupt handler on a core finds k by subtracting the base line. The delivery choice is made once per assertion. Configuration changes made while a source is being serviced apply only from its next delivery.

Top module: `irq_distrib_unit`

## Requirements
- R1: After reset every core line is low, the global enable is off, every source is masked, every destination mask is zero and every source is in fixed mode.
- R2: Command op 1 turns the global enable on and op 2 turns it off. While it is off no new delivery starts, even for a source that is configured, unmasked and high.
- R3: In fixed mode (op 4 with data bit 0 = 0) a delivery goes to the lowest-numbered core whose bit is set in the destination mask. Software is expected to set exactly one bit.
- R4: In round-robin mode (op 4 with data bit 0 = 1) each delivery goes to the first core after the core last served by that source that has its bit set in the mask, wrapping from the highest core to core 0. After reset, the last served core counts as the highest core, so the first delivery goes to the lowest set bit.
- R5: A masked source (op 5 masks, op 6 unmasks, addressed by cmd_irq_i) is not delivered. Unmasking a source that is held high delivers it.
- R6: A source whose destination mask (op 3, data = mask) is all zeros is never delivered.
- R7: Source k drives bit c*LINE_W + FIRST_LINE + k of core_lines_o for core c, where LINE_W = FIRST_LINE + NUM_IRQS. Bits below FIRST_LINE of each core's vector are always low.
- R8: A delivered line stays high until the owning core pulses ack_i bit c*NUM_IRQS + k. Completions from other cores are ignored, and the source input dropping low does not clear the line.
- R9: Timing: a source sampled high and eligible at a clock edge raises its line after that edge. A completion sampled at an edge lowers the line after that edge. If the source is still high, it is delivered again after the following edge.
- R10: A configuration command for a source that is in service does not move or drop the current delivery. It takes effect on the next delivery.
- R11: At any time, at most one core has its line high for a given source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_op_i | input | 3 | Command code: 0 none, 1 enable, 2 disable, 3 set mask, 4 set mode, 5 mask source, 6 unmask source |
| cmd_irq_i | input | IDX_W | Source addressed by the command |
| cmd_data_i | input | NUM_CORES | Destination mask for op 3; bit 0 selects round-robin for op 4 |
| irq_i | input | NUM_IRQS | Shared level-triggered sources |
| ack_i | input | NUM_CORES*NUM_IRQS | Completion pulses, bit c*NUM_IRQS + k for core c and source k |
| core_lines_o | output | NUM_CORES*LINE_W | Registered interrupt lines, LINE_W bits per core |

## Verification
The hardest state to reach from the ports is the round-robin rotation. Each step of it requires a full delivery and completion handshake, and the order only shows when the mask has a hole and the rotation wraps. The table walk holds one source high and pulses completions so that every step lands on a new core across the hole and through the wrap. Along the way it adds a completion from a core that does not own the source and an input drop during service. The directed tests change a destination while a delivery is outstanding, and they hold a source high across a completion to expose the redelivery gap.

// File: rtl/midu_pkg.sv
package midu_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ENABLE  = 3'd1,
    OP_DISABLE = 3'd2,
    OP_DEST    = 3'd3,
    OP_MODE    = 3'd4,
    OP_MASK    = 3'd5,
    OP_UNMASK  = 3'd6
  } midu_op_e;
endpackage

// File: rtl/midu_cfg_regs.sv
module midu_cfg_regs
  import midu_pkg::*;
#(
  parameter int NUM_IRQS  = 8,
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_IRQS > 1) ? $clog2(NUM_IRQS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic                          cmd_valid_i,
  input  logic [2:0]                    cmd_op_i,
  input  logic [IDX_W-1:0]              cmd_irq_i,
  input  logic [NUM_CORES-1:0]          cmd_data_i,
  output logic                          glob_en_o,
  output logic [NUM_IRQS*NUM_CORES-1:0] dest_o,
  output logic [NUM_IRQS-1:0]           rr_o,
  output logic [NUM_IRQS-1:0]           masked_o
);
  midu_op_e op;
  assign op = midu_op_e'(cmd_op_i);

  logic [NUM_CORES-1:0] dest_q [NUM_IRQS];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      glob_en_o <= 1'b0;
      rr_o      <= '0;
      masked_o  <= '1;
      for (int k = 0; k < NUM_IRQS; k++) dest_q[k] <= '0;
    end else if (cmd_valid_i) begin
      if (op == OP_ENABLE)  glob_en_o <= 1'b1;
      if (op == OP_DISABLE) glob_en_o <= 1'b0;
      for (int k = 0; k < NUM_IRQS; k++) begin
        if (cmd_irq_i == IDX_W'(k)) begin
          if (op == OP_DEST)   dest_q[k]   <= cmd_data_i;
          if (op == OP_MODE)   rr_o[k]     <= cmd_data_i[0];
          if (op == OP_MASK)   masked_o[k] <= 1'b1;
          if (op == OP_UNMASK) masked_o[k] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_IRQS; k++)
      dest_o[k*NUM_CORES +: NUM_CORES] = dest_q[k];
  end
endmodule

// File: rtl/midu_pick.sv
module midu_pick #(
  parameter int NUM_CORES = 4,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [NUM_CORES-1:0] dest_i,
  input  logic                 rr_i,
  input  logic [CORE_W-1:0]    last_i,
  output logic                 valid_o,
  output logic [CORE_W-1:0]    core_o
);
  int cand;

  always_comb begin
    valid_o = 1'b0;
    core_o  = '0;
    cand    = 0;
    if (!rr_i) begin
      for (int i = NUM_CORES - 1; i >= 0; i--) begin
        if (dest_i[i]) begin
          valid_o = 1'b1;
          core_o  = CORE_W'(i);
        end
      end
    end else begin
      for (int i = NUM_CORES; i >= 1; i--) begin
        cand = (int'(last_i) + i) % NUM_CORES;
        if (dest_i[cand]) begin
          valid_o = 1'b1;
          core_o  = CORE_W'(cand);
        end
      end
    end
  end
endmodule

// File: rtl/midu_slot.sv
module midu_slot #(
  parameter int NUM_CORES = 4,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 glob_en_i,
  input  logic                 irq_i,
  input  logic                 masked_i,
  input  logic [NUM_CORES-1:0] dest_i,
  input  logic                 rr_i,
  input  logic [NUM_CORES-1:0] ack_i,
  output logic [NUM_CORES-1:0] line_o
);
  logic              busy_q, busy_d;
  logic [CORE_W-1:0] owner_q, owner_d, last_q;
  logic              pick_valid;
  logic [CORE_W-1:0] pick_core;
  logic              dispatch, release_now;

  midu_pick #(.NUM_CORES(NUM_CORES)) pick_i (
    .dest_i (dest_i),
    .rr_i   (rr_i),
    .last_i (last_q),
    .valid_o(pick_valid),
    .core_o (pick_core)
  );

  assign dispatch    = !busy_q && irq_i && glob_en_i && !masked_i && pick_valid;
  assign release_now = busy_q && ack_i[owner_q];
  assign busy_d      = dispatch || (busy_q && !release_now);
  assign owner_d     = dispatch ? pick_core : owner_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      last_q  <= CORE_W'(NUM_CORES - 1);
      line_o  <= '0;
    end else begin
      busy_q  <= busy_d;
      owner_q <= owner_d;
      if (dispatch) last_q <= pick_core;
      for (int c = 0; c < NUM_CORES; c++)
        line_o[c] <= busy_d && (owner_d == CORE_W'(c));
    end
  end

  // R8: service holds until the owner completes
  a_r8_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && !ack_i[owner_q]) |=> (busy_q && $stable(owner_q)));

  // R8: owner completion ends service
  a_r8_release: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && ack_i[owner_q]) |=> !busy_q);

  // R4: a new delivery targets a core that was in the mask
  a_r4_target_in_dest: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(busy_q) |-> (|($past(dest_i) & (NUM_CORES'(1) << owner_q))));

  // R2: delivery starts only when enabled, unmasked and asserted
  a_r2_gated_start: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(busy_q) |-> $past(glob_en_i && !masked_i && irq_i));
endmodule

// File: rtl/irq_distrib_unit.sv
module irq_distrib_unit #(
  parameter int NUM_CORES  = 4,
  parameter int NUM_IRQS   = 8,
  parameter int FIRST_LINE = 4,
  localparam int IDX_W  = (NUM_IRQS > 1) ? $clog2(NUM_IRQS) : 1,
  localparam int LINE_W = FIRST_LINE + NUM_IRQS
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic                          cmd_valid_i,
  input  logic [2:0]                    cmd_op_i,
  input  logic [IDX_W-1:0]              cmd_irq_i,
  input  logic [NUM_CORES-1:0]          cmd_data_i,
  input  logic [NUM_IRQS-1:0]           irq_i,
  input  logic [NUM_CORES*NUM_IRQS-1:0] ack_i,
  output logic [NUM_CORES*LINE_W-1:0]   core_lines_o
);
  logic                          glob_en;
  logic [NUM_IRQS*NUM_CORES-1:0] dest;
  logic [NUM_IRQS-1:0]           rr, masked;
  logic [NUM_IRQS*NUM_CORES-1:0] slot_lines;

  midu_cfg_regs #(.NUM_IRQS(NUM_IRQS), .NUM_CORES(NUM_CORES)) cfg_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (cmd_op_i),
    .cmd_irq_i  (cmd_irq_i),
    .cmd_data_i (cmd_data_i),
    .glob_en_o  (glob_en),
    .dest_o     (dest),
    .rr_o       (rr),
    .masked_o   (masked)
  );

  for (genvar k = 0; k < NUM_IRQS; k++) begin : g_slot
    logic [NUM_CORES-1:0] ack_k, out_k;
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_gather
      assign ack_k[c] = ack_i[c*NUM_IRQS + k];
      assign out_k[c] = core_lines_o[c*LINE_W + FIRST_LINE + k];
    end

    midu_slot #(.NUM_CORES(NUM_CORES)) slot_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .glob_en_i(glob_en),
      .irq_i    (irq_i[k]),
      .masked_i (masked[k]),
      .dest_i   (dest[k*NUM_CORES +: NUM_CORES]),
      .rr_i     (rr[k]),
      .ack_i    (ack_k),
      .line_o   (slot_lines[k*NUM_CORES +: NUM_CORES])
    );

    // R11: one owner per shared source at the outputs
    a_r11_single_core: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(out_k));
  end

  always_comb begin
    core_lines_o = '0;
    for (int c = 0; c < NUM_CORES; c++)
      for (int k = 0; k < NUM_IRQS; k++)
        core_lines_o[c*LINE_W + FIRST_LINE + k] = slot_lines[k*NUM_CORES + c];
  end
endmodule

// File: tb/irq_distrib_unit_tb.sv
`timescale 1ns/1ps
module irq_distrib_unit_tb_top;
  localparam int NC = 4;
  localparam int NI = 8;
  localparam int FL = 4;
  localparam int LW = FL + NI;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_op = '0;
  logic [2:0]        cmd_irq = '0;
  logic [NC-1:0]     cmd_data = '0;
  logic [NI-1:0]     irq = '0;
  logic [NC*NI-1:0]  ack = '0;
  logic [NC*LW-1:0]  lines;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  irq_distrib_unit #(.NUM_CORES(NC), .NUM_IRQS(NI), .FIRST_LINE(FL)) dut_i (
    .clk_i(clk), .rst_i(rst), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_irq_i(cmd_irq), .cmd_data_i(cmd_data), .irq_i(irq), .ack_i(ack),
    .core_lines_o(lines)
  );

  // vector: lvl, ack_en, ack_core[1:0], exp_valid, 0, exp_core[1:0]
  localparam logic [7:0] RR_VEC [14] = '{
    8'h88, 8'h88, 8'hD8, 8'h08, 8'hC0, 8'h89, 8'hD0,
    8'h8B, 8'h70, 8'h00, 8'h88, 8'hC0, 8'h89, 8'h50
  };

  // 7 = no core, 6 = more than one core
  function automatic int owner_of(int k);
    int n = 0, who = 7;
    for (int c = 0; c < NC; c++)
      if (lines[c*LW + FL + k]) begin n++; who = c; end
    return (n > 1) ? 6 : who;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cmd(int op, int k, int data);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_irq = 3'(k); cmd_data = NC'(data);
    step();
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic pulse_ack(int c, int k);
    ack[c*NI + k] = 1'b1;
    step();
    ack = '0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 lines after reset", int'(|lines), 0);

    // R2 nothing before enable
    cmd(3, 0, 4'b0010); cmd(6, 0, 0);
    irq[0] = 1'b1;
    repeat (3) step();
    chk("R2 no delivery before enable", owner_of(0), 7);
    cmd(1, 0, 0);
    step();
    // R7 exact line position, low lines stay zero
    chk("R7 line position", int'(lines == (NC*LW)'(1) << (1*LW + FL + 0)), 1);
    chk("R3 fixed single bit", owner_of(0), 1);
    irq[0] = 1'b0;
    pulse_ack(1, 0);
    chk("R8 owner ack clears", owner_of(0), 7);

    // R5 masked by default
    cmd(3, 1, 4'b0001);
    irq[1] = 1'b1;
    repeat (2) step();
    chk("R5 masked not delivered", owner_of(1), 7);
    cmd(6, 1, 0);
    step();
    chk("R5 unmask delivers", owner_of(1), 0);
    irq[1] = 1'b0;
    pulse_ack(0, 1);

    // R6 zero mask
    cmd(6, 3, 0);
    irq[3] = 1'b1;
    repeat (3) step();
    chk("R6 zero mask suppressed", owner_of(3), 7);
    irq[3] = 1'b0;

    // R3 fixed mode repeated, R9 redelivery timing
    cmd(3, 4, 4'b0100); cmd(6, 4, 0);
    irq[4] = 1'b1;
    step();
    chk("R3 fixed to core2", owner_of(4), 2);
    pulse_ack(2, 4);
    chk("R9 gap after ack", owner_of(4), 7);
    step();
    chk("R9 redelivered to core2", owner_of(4), 2);
    irq[4] = 1'b0;
    pulse_ack(2, 4);

    // R10 reconfigure during service
    cmd(3, 5, 4'b0001); cmd(6, 5, 0);
    irq[5] = 1'b1;
    step();
    chk("R10 initial owner", owner_of(5), 0);
    cmd(3, 5, 4'b1000);
    chk("R10 owner kept during service", owner_of(5), 0);
    pulse_ack(0, 5);
    chk("R10 released", owner_of(5), 7);
    step();
    chk("R10 new mask on next delivery", owner_of(5), 3);
    irq[5] = 1'b0;
    pulse_ack(3, 5);

    // R4 round-robin walk on source 2, mask 1011
    cmd(3, 2, 4'b1011); cmd(4, 2, 1); cmd(6, 2, 0);
    for (int i = 0; i < 14; i++) begin
      logic [7:0] v;
      v = RR_VEC[i];
      irq[2] = v[7];
      if (v[6]) ack[int'(v[5:4])*NI + 2] = 1'b1;
      step();
      ack = '0;
      chk($sformatf("R4 R8 R11 rr vector %0d", i), owner_of(2), v[3] ? int'(v[1:0]) : 7);
    end
    irq[2] = 1'b0;

    // R2 disable stops new deliveries
    cmd(3, 6, 4'b0001); cmd(6, 6, 0);
    cmd(2, 0, 0);
    irq[6] = 1'b1;
    repeat (3) step();
    chk("R2 disabled no delivery", owner_of(6), 7);
    cmd(1, 0, 0);
    step();
    chk("R2 re-enable delivers", owner_of(6), 0);
    chk("R7 low lines zero", int'(lines[FL-1:0] | lines[LW +: FL]), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule